// File: doc/BRIEF.md
# Fractional Divisor Baud Rate Generator

This block turns a fast reference clock into the timing strobes for one serial channel. A front stage either passes every reference cycle through or keeps one in four. A programmable divider then counts those prescaled cycles. The divisor has a 16-bit whole part, supplied as a high byte and a low byte, and a 4-bit fraction in sixteenths. The fraction is spread over successive periods, so the long-run average period is exactly the programmed value.

The block has two outputs, and both are single-cycle strobes. The first is a sampling strobe at the oversampled rate. The second is a bit strobe, which is derived from the sampling strobe by counting 16, 8 or 4 of them according to an oversampling select. A receiver and a transmitter sharing the channel use the sampling strobe to sample the line and the bit strobe to shift data.

A change to the divisor inputs never cuts a period short. The period already running finishes with its old length, and the new value takes over at the next period boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `samp_tick` and `bit_tick` are both 0 from the first clock edge onward.
- R2: With `pre_sel`=0 and fraction 0, consecutive `samp_tick` pulses are exactly N clock cycles apart, where N = `div_hi`*256 + `div_lo`. For N=1, `samp_tick` is high on every cycle.
- R3: A whole divisor of 0 behaves exactly like a whole divisor of 1.
- R4: With fraction f, period k after a divisor load lasts N+1 prescaled cycles when floor(k*f/16) > floor((k-1)*f/16), and N otherwise. Over any 16 periods, exactly f of them are stretched.
- R5: With `pre_sel`=1, every period is 4 times as many reference cycles as with `pre_sel`=0, and two `samp_tick` pulses are never on adjacent cycles.
- R6: A change to the divisor inputs leaves the running period at its old length. It takes effect for the period that starts at the next `samp_tick`, and the fraction accumulator is cleared at that point, so period k=1 of the new setting follows R4.
- R7: `bit_tick` is high only in the cycle that follows a `samp_tick`. With `osr_sel`=00 it is high once per 16 `samp_tick` pulses.
- R8: With `osr_sel`=01, `bit_tick` comes once per 8 `samp_tick` pulses. With `osr_sel`=10 or 11, it comes once per 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_lo | input | 8 | Low byte of the whole divisor |
| div_hi | input | 8 | High byte of the whole divisor |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| pre_sel | input | 1 | 0: prescale by 1, 1: prescale by 4 |
| osr_sel | input | 2 | Oversampling: 00 = 16X, 01 = 8X, 1x = 4X |
| samp_tick | output | 1 | One-cycle strobe at the sampling rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
Each `samp_tick` rises one cycle after the clock edge that ends a period, and the next period is loaded on that same edge. A setting applied half a cycle before an edge therefore first shows up as the interval that starts at the next observed `samp_tick`. `bit_tick` comes one cycle after the sampling strobe that completes its count. The bench changes inputs only on falling edges and reads the outputs on falling edges. It measures every interval in whole cycles, from one observed strobe to the next, and compares it with the R4 formula computed in the bench. For `bit_tick` it also confirms that a `samp_tick` was seen on the falling edge just before.

// File: rtl/fbg_pkg.sv
// Shared types for the fractional baud rate generator.
// Assumes the oversampling select is two bits wide.
package fbg_pkg;

    typedef enum logic [1:0] {
        OSR_X16  = 2'b00,
        OSR_X8   = 2'b01,
        OSR_X4   = 2'b10,
        OSR_X4_B = 2'b11
    } osr_mode_t;

    localparam int OSR_CNT_W = 4;

    // Number of sampling strobes that make up one bit for a given mode.
    function automatic logic [OSR_CNT_W:0] osr_count(input osr_mode_t m);
        case (m)
            OSR_X16: osr_count = 5'd16;
            OSR_X8:  osr_count = 5'd8;
            default: osr_count = 5'd4;
        endcase
    endfunction

endpackage

// File: rtl/fbg_prescaler.sv
// Prescaler: raises step_o once every PRE_DIV reference cycles when
// div_sel is 1, and on every cycle when div_sel is 0.
// The phase counter runs freely, so changing div_sel never stalls it.
module fbg_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic step_o
);
    localparam int PH_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRE_DIV - 1);

    logic [PH_W-1:0] phase_q;

    // Free-running phase counter that wraps at PRE_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Pass every cycle through, or only the last phase of each group.
    always_comb begin
        step_o = div_sel ? (phase_q == PH_LAST) : 1'b1;
    end
endmodule

// File: rtl/fbg_divider.sv
// Fractional divider. It counts step_en events and raises tick_o once per
// period. The period is max(int_div,1) steps, plus one step whenever the
// fraction accumulator carries. New divisor inputs are taken only at a
// period boundary. When they differ from the active values, the
// accumulator restarts from zero.
// Assumes int_div and frac_div are held steady by the host between writes.
module fbg_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    output logic              tick_o
);
    localparam logic [INT_W-1:0] ONE = INT_W'(1);

    logic [INT_W-1:0]  cnt_q;
    logic [INT_W-1:0]  act_int_q;
    logic [FRAC_W-1:0] act_frac_q;
    logic [FRAC_W-1:0] acc_q;
    logic              tick_q;

    logic [INT_W-1:0]  eff_int;
    logic              cfg_changed;
    logic [FRAC_W-1:0] acc_base;
    logic [FRAC_W:0]   acc_sum;
    logic [INT_W-1:0]  reload;
    logic              at_edge;

    // Next-period length from the live inputs and the accumulator.
    always_comb begin
        eff_int     = (int_div == '0) ? ONE : int_div;
        cfg_changed = (int_div != act_int_q) || (frac_div != act_frac_q);
        acc_base    = cfg_changed ? '0 : acc_q;
        acc_sum     = {1'b0, acc_base} + {1'b0, frac_div};
        reload      = eff_int - ONE + {{(INT_W-1){1'b0}}, acc_sum[FRAC_W]};
        at_edge     = step_en && (cnt_q == '0);
    end

    // Down-counter with boundary reload of the divisor and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            act_int_q  <= ONE;
            act_frac_q <= '0;
            acc_q      <= '0;
        end else if (at_edge) begin
            cnt_q      <= reload;
            act_int_q  <= int_div;
            act_frac_q <= frac_div;
            acc_q      <= acc_sum[FRAC_W-1:0];
        end else if (step_en) begin
            cnt_q      <= cnt_q - ONE;
        end
    end

    // Registered one-cycle strobe at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= 1'b0;
        else
            tick_q <= at_edge;
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/fbg_bit_counter.sv
// Bit-rate stage: counts sampling strobes and raises bit_o in the cycle
// after the strobe that completes 16, 8 or 4 of them, as mode selects.
// A count already past a smaller new limit wraps on the next strobe.
module fbg_bit_counter
    import fbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      samp_in,
    input  osr_mode_t mode,
    output logic      bit_o
);
    logic [OSR_CNT_W-1:0] cnt_q;
    logic [OSR_CNT_W-1:0] last_val;
    logic                 bit_q;
    logic [OSR_CNT_W:0]   lim;

    // Last count value for the selected oversampling ratio.
    always_comb begin
        lim      = osr_count(mode) - 5'd1;
        last_val = lim[OSR_CNT_W-1:0];
    end

    // Strobe counter with wrap on the final strobe of a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= 1'b0;
        end else begin
            bit_q <= samp_in && (cnt_q >= last_val);
            if (samp_in)
                cnt_q <= (cnt_q >= last_val) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/frac_baud_gen.sv
// Top of the fractional baud rate generator: prescaler, then fractional
// divider, then bit-rate counter. The whole divisor is assembled from two
// BYTE_W-bit halves. Assumes one reference clock and a synchronous
// active-low reset.
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              pre_sel,
    input  logic [1:0]        osr_sel,
    output logic              samp_tick,
    output logic              bit_tick
);
    localparam int INT_W = 2 * BYTE_W;

    logic             step_en;
    logic [INT_W-1:0] int_div;
    osr_mode_t        mode;

    // Assemble the whole divisor and decode the oversampling mode.
    always_comb begin
        int_div = {div_hi, div_lo};
        mode    = osr_mode_t'(osr_sel);
    end

    fbg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (pre_sel),
        .step_o  (step_en)
    );

    fbg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .int_div  (int_div),
        .frac_div (div_frac),
        .tick_o   (samp_tick)
    );

    fbg_bit_counter u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_in (samp_tick),
        .mode    (mode),
        .bit_o   (bit_tick)
    );
endmodule

// File: rtl/fbg_checker.sv
// Port-level properties for frac_baud_gen, attached through bind.
module fbg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] div_lo,
    input logic [7:0] div_hi,
    input logic [3:0] div_frac,
    input logic       pre_sel,
    input logic       samp_tick,
    input logic       bit_tick
);
    // R1: a cycle held in reset leaves both strobes low on the next cycle.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!samp_tick && !bit_tick));

    // R2: a unit divisor held steady keeps the sampling strobe high.
    assert_unit_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_tick && !pre_sel && div_lo == 8'd1 && div_hi == 8'd0 &&
         div_frac == 4'd0 && $stable(div_lo) && $stable(div_hi) &&
         $stable(div_frac) && $stable(pre_sel)) |=> samp_tick);

    // R3: a zero divisor behaves like a unit divisor.
    assert_zero_as_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_tick && !pre_sel && div_lo == 8'd0 && div_hi == 8'd0 &&
         div_frac == 4'd0 && $stable(div_lo) && $stable(div_hi) &&
         $stable(div_frac) && $stable(pre_sel)) |=> samp_tick);

    // R5: with the divide-by-4 prescaler, strobes are never adjacent.
    assert_prescale_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel && $past(pre_sel) && samp_tick) |=> !samp_tick);

    // R7: the bit strobe only follows a sampling strobe.
    assert_bit_after_samp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(samp_tick));
endmodule

bind frac_baud_gen fbg_checker u_fbg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_lo    (div_lo),
    .div_hi    (div_hi),
    .div_frac  (div_frac),
    .pre_sel   (pre_sel),
    .samp_tick (samp_tick),
    .bit_tick  (bit_tick)
);

// File: tb/test_frac_baud_gen.sv
// Directed bench for frac_baud_gen: one task per scenario.
module test_frac_baud_gen;
    localparam int WAIT_MAX = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] div_hi = 8'd0;
    logic [3:0] div_frac = 4'd0;
    logic       pre_sel = 1'b0;
    logic [1:0] osr_sel = 2'b00;
    logic       samp_tick;
    logic       bit_tick;

    int  total = 0;
    int  bad = 0;
    longint cyc = 0;
    bit  done = 1'b0;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .div_frac(div_frac), .pre_sel(pre_sel), .osr_sel(osr_sel),
        .samp_tick(samp_tick), .bit_tick(bit_tick)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_gap(input int n, input int f, input int k, input int pre);
        int base = (n == 0) ? 1 : n;
        int extra = ((k * f) / 16) - (((k - 1) * f) / 16);
        return longint'((base + extra) * pre);
    endfunction

    task automatic wait_samp(output longint t);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!samp_tick && guard < WAIT_MAX);
        if (!samp_tick) check(1'b0, "samp_tick timeout", 0, 1);
        t = cyc;
    endtask

    task automatic wait_bit(output longint t, output bit prev_s);
        int guard = 0;
        bit ps;
        do begin
            ps = samp_tick;
            @(negedge clk);
            guard++;
        end while (!bit_tick && guard < WAIT_MAX);
        if (!bit_tick) check(1'b0, "bit_tick timeout", 0, 1);
        t = cyc;
        prev_s = ps;
    endtask

    task automatic set_div(input int n, input int f, input bit pre);
        @(negedge clk);
        div_lo   = n[7:0];
        div_hi   = n[15:8];
        div_frac = f[3:0];
        pre_sel  = pre;
    endtask

    // Measures cnt intervals after the load boundary against the R4 formula.
    task automatic run_gaps(input int n, input int f, input bit pre, input int cnt,
                            input string req, output longint last_t);
        longint t0, t1;
        set_div(n, f, pre);
        wait_samp(t0);
        for (int k = 1; k <= cnt; k++) begin
            wait_samp(t1);
            check(t1 - t0 == exp_gap(n, f, k, pre ? 4 : 1), req, t1 - t0,
                  exp_gap(n, f, k, pre ? 4 : 1));
            t0 = t1;
        end
        last_t = t0;
    endtask

    // R1: both strobes low while reset is held.
    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!samp_tick && !bit_tick, "R1 reset quiet", {samp_tick, bit_tick}, 0);
        end
        rst_n = 1'b1;
    endtask

    // R2: a unit divisor gives a strobe on every cycle.
    task automatic t_unit;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(samp_tick, "R2 unit divisor", samp_tick, 1);
        end
    endtask

    // R2 and R3: whole divisors, including high byte and zero.
    task automatic t_integer;
        longint lt;
        run_gaps(5, 0, 1'b0, 4, "R2 divisor 5", lt);
        run_gaps(259, 0, 1'b0, 2, "R2 divisor 0x0103", lt);
        run_gaps(0, 0, 1'b0, 6, "R3 zero as one", lt);
    endtask

    // R4: fractional spreading for several fractions.
    task automatic t_frac;
        longint lt;
        run_gaps(3, 5, 1'b0, 16, "R4 n3 f5", lt);
        run_gaps(2, 15, 1'b0, 16, "R4 n2 f15", lt);
        run_gaps(0, 8, 1'b0, 16, "R4 R3 n0 f8", lt);
    endtask

    // R5: the divide-by-4 prescaler scales every period by 4.
    task automatic t_prescale;
        longint lt;
        run_gaps(3, 0, 1'b1, 4, "R5 prescale n3", lt);
        run_gaps(2, 4, 1'b1, 8, "R5 prescale n2 f4", lt);
    endtask

    // R6: the running period ends at its old length, the accumulator is cleared.
    task automatic t_boundary;
        longint t0, t1, t2;
        run_gaps(40, 0, 1'b0, 1, "R6 setup", t0);
        repeat (5) @(negedge clk);
        div_lo = 8'd6;
        wait_samp(t1);
        check(t1 - t0 == 40, "R6 old period kept", t1 - t0, 40);
        wait_samp(t2);
        check(t2 - t1 == 6, "R6 new period", t2 - t1, 6);
        run_gaps(2, 4, 1'b0, 2, "R6 accumulate", t0);
        run_gaps(2, 8, 1'b0, 4, "R6 accumulator cleared", t0);
    endtask

    // R7 and R8: bit strobe spacing per oversampling mode.
    task automatic t_bits(input logic [1:0] m, input int ratio, input string req);
        longint t0, t1;
        bit ps;
        set_div(2, 0, 1'b0);
        osr_sel = m;
        wait_bit(t0, ps);
        wait_bit(t0, ps);
        for (int i = 0; i < 3; i++) begin
            wait_bit(t1, ps);
            check(t1 - t0 == longint'(2 * ratio), req, t1 - t0, 2 * ratio);
            check(ps, {req, " follows samp_tick"}, ps, 1);
            t0 = t1;
        end
    endtask

    initial begin
        t_reset();
        t_unit();
        t_integer();
        t_frac();
        t_prescale();
        t_boundary();
        t_bits(2'b00, 16, "R7 16X");
        t_bits(2'b01, 8, "R8 8X");
        t_bits(2'b10, 4, "R8 4X");
        t_bits(2'b11, 4, "R8 4X alt");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule